// File: doc/BRIEF.md
# Double-Data-Rate Two-Port Burst SRAM

This block is a synthesizable model of a static memory with one port that only writes and one that only reads. Both ports share a single address bus, and every transfer moves a burst of two words on the two edges of one clock. A read request and a write request may start on the same rising edge, and neither port waits for the other. Each location holds two words. The first word of a burst is the low half of the location and the second word is the high half.

A read takes its address on a rising edge. A write takes its first data word on a rising edge and its address and second word on the falling edge that follows. The written location is committed to the array on the next rising edge. Until that happens, any read of the same address gets the new bytes forwarded from the staging register. A per-request mode input selects a read latency of one cycle or one and a half cycles. A valid output marks the two half-cycles in which read data is driven, and it drops as soon as the burst ends.

Top module: `dual_rate_sram`

## Requirements
- R1: While rst_n is low, and after it rises until the first read burst, q_valid is low.
- R2: A read starts when rd_sel_n is low at a rising clk edge, and addr is sampled on that same edge. The burst returns bits W-1:0 of the location first and bits 2W-1:W second.
- R3: A write starts when wr_sel_n is low at a rising clk edge, which samples word 0 (wdata) and its byte mask (wbyte_n). The next falling edge samples the write address (addr), word 1 and its mask. The location is stored as {word1, word0}.
- R4: wbyte_n is active low and is sampled with each word. Bit 0 guards the low byte of the word (bits W/2-1:0) and bit 1 guards the high byte. A byte whose select is high keeps its previous stored value.
- R5: With half_lat low at the request edge, word 0 is driven during the high phase that follows the next rising edge, and word 1 during the low phase after it.
- R6: With half_lat high at the request edge, word 0 is driven during the low phase of the next cycle, and word 1 during the high phase after the rising edge that follows.
- R7: q_valid is high in exactly the two half-cycles that carry a burst's words and low in every other half-cycle.
- R8: A read returns the contents after every write that started on or before the read's request edge. This includes a write that started on that same edge and is not yet committed, with its byte masks applied.
- R9: While wr_sel_n is high at a rising edge, the write-side inputs of that cycle change no location. The read port behaves the same whether or not a write runs alongside it.
- R10: Read requests on consecutive rising edges return back-to-back bursts with no idle half-cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel_n | input | 1 | Read request, active low, sampled on rising edge |
| wr_sel_n | input | 1 | Write request, active low, sampled on rising edge |
| half_lat | input | 1 | Latency mode: 1 = one and a half cycles, 0 = one cycle |
| addr | input | $clog2(DEPTH) | Read address on rising edge, write address on falling edge |
| wdata | input | W | Write word 0 on rising edge, word 1 on falling edge |
| wbyte_n | input | 2 | Active-low byte write selects for the current word |
| q | output | W | Read data word |
| q_valid | output | 1 | High while a read word is driven |

## Verification
The latency assertions assume that half_lat is steady from a read request until its burst has left the port. The bench therefore changes the mode only after three idle cycles, and it never reads a location before every byte of it has been written. The bench drives rising-edge inputs before each rising edge and falling-edge inputs before each falling edge, so every sample sees settled values. Random cycles mix reads, writes, shared addresses and partial masks. Directed cases cover same-edge forwarding in both modes, deselected writes and unbroken read streams.

// File: rtl/dual_rate_sram.sv
module dual_rate_sram #(
  parameter int DEPTH = 64,
  parameter int W     = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_sel_n,
  input  logic                     wr_sel_n,
  input  logic                     half_lat,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [W-1:0]             wdata,
  input  logic [1:0]               wbyte_n,
  output logic [W-1:0]             q,
  output logic                     q_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = 2 * W;
  localparam int BW = W / 2;
  localparam int NB = LW / BW;

  logic [LW-1:0] mem [DEPTH];

  logic          s1, m1, s2, m2;
  logic [AW-1:0] raddr;
  logic [LW-1:0] line, fwd;
  logic          pos_v, neg_v;
  logic [W-1:0]  pos_q, neg_q;

  logic          w1;
  logic [W-1:0]  wd0;
  logic [1:0]    wb0;
  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [LW-1:0] pend_d;
  logic [NB-1:0] pend_m;

  always_comb begin
    fwd = mem[raddr];
    if (pend_v && pend_a == raddr)
      for (int b = 0; b < NB; b++)
        if (!pend_m[b]) fwd[b*BW +: BW] = pend_d[b*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; m1 <= 1'b0; s2 <= 1'b0; m2 <= 1'b0;
      raddr <= '0; line <= '0;
      pos_v <= 1'b0; pos_q <= '0;
      w1 <= 1'b0; wd0 <= '0; wb0 <= '1;
    end else begin
      s1    <= !rd_sel_n;
      m1    <= half_lat;
      s2    <= s1;
      m2    <= m1;
      if (!rd_sel_n) raddr <= addr;
      line  <= fwd;
      pos_v <= (s1 && !m1) || (s2 && m2);
      pos_q <= (s1 && !m1) ? fwd[W-1:0] : line[LW-1:W];
      w1    <= !wr_sel_n;
      wd0   <= wdata;
      wb0   <= wbyte_n;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_v <= 1'b0; pend_a <= '0; pend_d <= '0; pend_m <= '1;
      neg_v  <= 1'b0; neg_q <= '0;
    end else begin
      pend_v <= w1;
      pend_a <= addr;
      pend_d <= {wdata, wd0};
      pend_m <= {wbyte_n, wb0};
      neg_v  <= s2;
      neg_q  <= m2 ? line[W-1:0] : line[LW-1:W];
    end

  always_ff @(posedge clk)
    if (pend_v)
      for (int b = 0; b < NB; b++)
        if (!pend_m[b]) mem[pend_a][b*BW +: BW] <= pend_d[b*BW +: BW];

  assign q       = clk ? pos_q : neg_q;
  assign q_valid = clk ? pos_v : neg_v;
endmodule

// File: rtl/dual_rate_sram_chk.sv
module dual_rate_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_sel_n,
  input logic wr_sel_n,
  input logic half_lat,
  input logic pos_v,
  input logic pend_v
);
  // R5
  lo_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && !half_lat) |=> ##1 pos_v);

  // R6
  hi_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && half_lat) |=> ##2 pos_v);

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_n && $past(rd_sel_n)) |=> ##1 !pos_v);

  // R3
  wr_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel_n |=> pend_v);

  // R9
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel_n |=> !pend_v);
endmodule

bind dual_rate_sram dual_rate_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .half_lat(half_lat), .pos_v(pos_v), .pend_v(pend_v)
);

// File: tb/test_dual_rate_sram.sv
module test_dual_rate_sram;
  localparam int T     = 10;
  localparam int DEPTH = 64;
  localparam int W     = 18;
  localparam int AW    = $clog2(DEPTH);
  localparam int SLOTS = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1, half_lat = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [1:0]    wbyte_n = 2'b11;
  logic [W-1:0]  q;
  logic          q_valid;

  dual_rate_sram #(.DEPTH(DEPTH), .W(W)) i_dual_rate_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .half_lat(half_lat), .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n),
    .q(q), .q_valid(q_valid)
  );

  always #(T/2) clk = ~clk;

  int checks = 0, fails = 0, pc = 0;
  logic          exp_v [SLOTS];
  logic [W-1:0]  exp_q [SLOTS];
  string         exp_t [SLOTS];
  logic [2*W-1:0] bm [DEPTH];

  function automatic logic [2*W-1:0] merge(input logic [2*W-1:0] old,
      input logic [W-1:0] d0, input logic [W-1:0] d1,
      input logic [1:0] m0, input logic [1:0] m1);
    logic [2*W-1:0] r = old;
    logic [2*W-1:0] nd = {d1, d0};
    logic [3:0] m = {m1, m0};
    for (int b = 0; b < 4; b++)
      if (!m[b]) r[b*(W/2) +: W/2] = nd[b*(W/2) +: W/2];
    return r;
  endfunction

  task automatic check_edge(input int e);
    if (!rst_n || e >= SLOTS) return;
    checks++;
    if (exp_v[e]) begin
      if (q_valid !== 1'b1 || q !== exp_q[e]) begin
        fails++;
        $display("FAIL %s edge %0d: valid=%0b q=%h expected valid=1 q=%h",
                 exp_t[e], e, q_valid, q, exp_q[e]);
      end
    end else if (q_valid !== 1'b0) begin
      fails++;
      $display("FAIL R7 edge %0d: valid=%0b expected valid=0", e, q_valid);
    end
  endtask

  always @(posedge clk) begin
    int e;
    e = 2 * pc;
    pc = pc + 1;
    #2 check_edge(e);
  end

  always @(negedge clk) begin
    int e;
    e = 2 * pc - 1;
    #2 check_edge(e);
  end

  task automatic cyc(input logic rd, input logic [AW-1:0] ra,
                     input logic wr, input logic [AW-1:0] wa,
                     input logic [W-1:0] d0, input logic [W-1:0] d1,
                     input logic [1:0] m0, input logic [1:0] m1,
                     input string tag);
    int k, base;
    logic [2*W-1:0] ln;
    @(negedge clk); #3;
    k = pc;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = rd ? ra : wa + 1'b1;
    wdata = d0; wbyte_n = m0;
    @(posedge clk); #3;
    addr = wa; wdata = d1; wbyte_n = m1;
    if (wr) bm[wa] = merge(bm[wa], d0, d1, m0, m1);
    if (rd) begin
      ln = bm[ra];
      base = half_lat ? 2*k + 3 : 2*k + 2;
      if (base + 1 < SLOTS) begin
        exp_v[base] = 1'b1;   exp_q[base] = ln[W-1:0];     exp_t[base] = tag;
        exp_v[base+1] = 1'b1; exp_q[base+1] = ln[2*W-1:W]; exp_t[base+1] = tag;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc(1'b0, '0, 1'b0, AW'($urandom), W'($urandom), W'($urandom),
          2'($urandom), 2'($urandom), "R7");
  endtask

  task automatic set_mode(input logic m);
    idle(3);
    @(negedge clk); #3;
    half_lat = m;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(T * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    int unsigned seed;
    logic [W-1:0] d0, d1;
    seed = $urandom(32'd2024);
    for (int i = 0; i < SLOTS; i++) begin exp_v[i] = 1'b0; exp_q[i] = '0; exp_t[i] = "R7"; end
    for (int i = 0; i < DEPTH; i++) bm[i] = '0;

    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (q_valid !== 1'b0) begin
      fails++; $display("FAIL R1 during reset: valid=%0b expected 0", q_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R9: fill every location while reading the previous one in parallel
    for (int i = 0; i < DEPTH; i++)
      cyc(i > 0, AW'(i - 1), 1'b1, AW'(i), W'($urandom), W'($urandom),
          2'b00, 2'b00, "R2");
    cyc(1'b1, AW'(DEPTH - 1), 1'b0, '0, '0, '0, 2'b11, 2'b11, "R2");
    idle(3);

    // R4: partial byte masks, then read back
    cyc(1'b0, '0, 1'b1, 6'd5, 18'h3ABCD, 18'h01234, 2'b10, 2'b01, "R4");
    cyc(1'b1, 6'd5, 1'b0, '0, '0, '0, 2'b11, 2'b11, "R4");
    idle(3);

    // R8: same-edge forwarding, low latency then high latency
    cyc(1'b1, 6'd7, 1'b1, 6'd7, 18'h2AAAA, 18'h15555, 2'b00, 2'b01, "R8");
    cyc(1'b1, 6'd7, 1'b1, 6'd8, 18'h11111, 18'h22222, 2'b01, 2'b10, "R8");
    set_mode(1'b1);
    cyc(1'b1, 6'd7, 1'b1, 6'd7, 18'h0F0F0, 18'h30303, 2'b10, 2'b00, "R8");
    cyc(1'b1, 6'd7, 1'b0, '0, '0, '0, 2'b11, 2'b11, "R6");
    idle(3);

    // R9: deselected write leaves location 9 untouched
    cyc(1'b0, '0, 1'b0, 6'd9, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, "R9");
    cyc(1'b1, 6'd9, 1'b0, '0, '0, '0, 2'b11, 2'b11, "R9");

    // R10: unbroken read stream in high latency, then in low latency
    for (int i = 0; i < 8; i++)
      cyc(1'b1, AW'(i * 3), 1'b0, '0, '0, '0, 2'b11, 2'b11, "R10");
    set_mode(1'b0);
    for (int i = 0; i < 8; i++)
      cyc(1'b1, AW'(i * 5), 1'b0, '0, '0, '0, 2'b11, 2'b11, "R10");

    // R5 R6 R8: constrained random mix on a narrow address range
    for (int p = 0; p < 6; p++) begin
      set_mode(p[0]);
      for (int i = 0; i < 500; i++) begin
        d0 = W'($urandom); d1 = W'($urandom);
        cyc(($urandom % 3) != 0, AW'($urandom % 8),
            ($urandom % 2) != 0, AW'($urandom % 8), d0, d1,
            2'($urandom), 2'($urandom), p[0] ? "R6" : "R5");
      end
    end
    idle(4);
    report();
  end
endmodule